// File: doc/BRIEF.md
# Receive Character Queue with Trigger Threshold

This block holds received characters between the serial deserializer of a 16550-style UART and the host. Each stored entry carries an 8-bit character and three error flags: parity, framing and break. The host sees the oldest entry at a read port and removes it with a read strobe. A status byte reports data-ready, overrun, the error flags of the oldest entry, and whether any stored entry is in error.

Two requests go to the interrupt logic. The data-available request rises when the number of stored characters reaches a threshold that a 2-bit code selects. The character-timeout request rises when characters have waited for four character times with no host read and no new arrival. A control byte written by the host sets queue mode, the threshold code and a DMA select bit, and triggers flushes. When queue mode is off, the block keeps at most one character, like a plain holding register.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the level is 0, the status byte is 0x00, both requests are low, tx_flush and dma_sel are low, queue mode is off and the threshold code is 00.
- R2: In queue mode up to DEPTH characters are kept. rd_char and status bits 4:2 ({break, framing, parity}) show the oldest entry. Entries leave in arrival order, and level equals the number stored.
- R3: A character that arrives while the queue is full, with no read in the same cycle, is dropped and sets status bit 1 (overrun). The level stays unchanged. A status read (stat_rd) clears bit 1. A read of an empty queue has no effect on the level.
- R4: In queue mode, rda_req is high exactly when level is at least the threshold: control bits 7:6 = 00 → 1, 01 → 4, 10 → 8, 11 → 14.
- R5: Control byte fields: bit 0 is queue mode, bit 1 flushes the receive queue, bit 2 pulses tx_flush high for the one cycle after the write, and bit 3 is dma_sel. Bits 1 and 2 act once and are not retained. A receive flush empties the queue and clears status bit 7.
- R6: Status bit 0 is high when at least one character is stored. Status bit 7 is high when any stored entry carries a parity, framing or break flag.
- R7: In queue mode with a non-empty queue, cto_req rises after 4×CHAR_TICKS tick16 pulses with no write and no read. A write or a read clears it and restarts the count. Cycles without tick16 do not count.
- R8: With queue mode off, capacity is one character. A second character is dropped with overrun, rda_req is high whenever level is 1, and cto_req never rises.
- R9: A control write that changes bit 0 flushes the receive queue and pulses tx_flush. A write that keeps bit 0 unchanged and has bits 1 and 2 clear leaves the queue intact.
- R10: A write and a read in the same cycle on a full queue both take effect. The level stays at DEPTH and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Character strobe from the deserializer |
| wr_char | input | 8 | Received character |
| wr_perr | input | 1 | Parity error flag of the character |
| wr_ferr | input | 1 | Framing error flag of the character |
| wr_brk | input | 1 | Break flag of the character |
| rd_en | input | 1 | Host removes the oldest entry |
| stat_rd | input | 1 | Host reads the status byte (clears overrun) |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte |
| tick16 | input | 1 | One-cycle pulse at 16× the bit rate |
| rd_char | output | 8 | Character of the oldest entry |
| status | output | 8 | Status byte |
| level | output | $clog2(DEPTH+1) | Number of stored characters |
| rda_req | output | 1 | Data-available request |
| cto_req | output | 1 | Character-timeout request |
| tx_flush | output | 1 | One-cycle flush pulse for the transmit queue |
| dma_sel | output | 1 | DMA mode select |

## Verification
The assertions assume that every input carries a known value from the first clock after reset. They also assume that control writes are the only source of mode changes, so the capacity never drops below the level except in a cycle that also flushes. The bench drives every input to a defined value at time zero. It changes mode only through control writes, which flush the queue whenever bit 0 changes. It also keeps tick16 at a steady level through each timeout window, so the count of ticks to the request is known exactly.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rxq_entry_t;

  localparam int CTL_EN    = 0;
  localparam int CTL_RXCLR = 1;
  localparam int CTL_TXCLR = 2;
  localparam int CTL_DMA   = 3;

  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  rxq_entry_t       wdata,
  input  logic [AW-1:0]    raddr,
  output rxq_entry_t       rdata
);
  rxq_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  output logic       en,
  output logic       dma,
  output logic [1:0] trig,
  output logic       rx_flush,
  output logic       tx_flush
);
  logic mode_change;
  logic unused_bits;

  assign unused_bits = ^ctl_data[5:4];
  assign mode_change = ctl_wr && (ctl_data[CTL_EN] != en);
  assign rx_flush    = (ctl_wr && ctl_data[CTL_RXCLR]) || mode_change;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      dma      <= 1'b0;
      trig     <= 2'b00;
      tx_flush <= 1'b0;
    end else begin
      tx_flush <= (ctl_wr && ctl_data[CTL_TXCLR]) || mode_change;
      if (ctl_wr) begin
        en   <= ctl_data[CTL_EN];
        dma  <= ctl_data[CTL_DMA];
        trig <= ctl_data[7:6];
      end
    end
  end

  p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> ($stable(en) && $stable(dma) && $stable(trig)));
  p_tx_single_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> !tx_flush);
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int LIMIT = 64,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic hit
);
  logic [TW-1:0] tmr;

  assign hit = (tmr == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr || !run) tmr <= '0;
    else if (tick && !hit)  tmr <= tmr + 1'b1;
  end

  p_hit_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
    hit |-> run);
  p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr && run) |=> $stable(tmr));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CHAR_TICKS = 160,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LIMIT = 4 * CHAR_TICKS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_char,
  input  logic          wr_perr,
  input  logic          wr_ferr,
  input  logic          wr_brk,
  input  logic          rd_en,
  input  logic          stat_rd,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_data,
  input  logic          tick16,
  output logic [7:0]    rd_char,
  output logic [7:0]    status,
  output logic [CW-1:0] level,
  output logic          rda_req,
  output logic          cto_req,
  output logic          tx_flush,
  output logic          dma_sel
);
  logic          en, rx_flush;
  logic [1:0]    trig;
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, err_cnt, cap, thr;
  logic          full, empty, push, pop, drop, ovr, dr;
  logic          in_err, head_err;
  rxq_entry_t    wentry, head;

  rxq_ctl u_ctl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .en(en), .dma(dma_sel), .trig(trig),
    .rx_flush(rx_flush), .tx_flush(tx_flush)
  );

  assign cap   = en ? CW'(DEPTH) : CW'(1);
  assign thr   = en ? CW'(trig_level(trig)) : CW'(1);
  assign empty = (cnt == '0);
  assign full  = (cnt == cap);
  assign pop   = rd_en && !empty && !rx_flush;
  assign push  = wr_en && (!full || pop) && !rx_flush;
  assign drop  = wr_en && !push && !rx_flush;

  assign wentry   = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr, data: wr_char};
  assign in_err   = wr_brk || wr_ferr || wr_perr;
  assign head_err = head.brk || head.ferr || head.perr;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push), .waddr(wp), .wdata(wentry),
    .raddr(rp), .rdata(head)
  );

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || rx_flush) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      err_cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt     <= cnt + CW'(push) - CW'(pop);
      err_cnt <= err_cnt + CW'(push && in_err) - CW'(pop && head_err);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovr <= 1'b0;
    else if (drop)    ovr <= 1'b1;
    else if (stat_rd) ovr <= 1'b0;
  end

  rxq_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clr(rx_flush || wr_en || rd_en),
    .run(en && !empty), .tick(tick16), .hit(cto_req)
  );

  assign dr      = !empty;
  assign level   = cnt;
  assign rd_char = head.data;
  assign rda_req = (cnt >= thr);
  assign status  = {err_cnt != '0, 2'b00, head.brk & dr, head.ferr & dr,
                    head.perr & dr, ovr, dr};

  p_level_cap_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= cap);
  p_ovr_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en && !rx_flush) |=> (ovr && $stable(cnt)));
  p_rda_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    rda_req |-> dr);
  p_flush_empty_r5: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> (cnt == '0 && err_cnt == '0));
  p_err_bound_r6: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= cnt);
  p_cto_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    cto_req |-> dr);
  p_single_slot_r8: assert property (@(posedge clk) disable iff (rst)
    !en |-> (cnt <= CW'(1) && !cto_req));
  p_full_swap_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && full && !rx_flush) |=> (cnt == $past(cnt)));
endmodule

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
  localparam int DEPTH = 16;
  localparam int CT    = 2;
  localparam int LIM   = 4 * CT;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0;
  logic rd_en = 0, stat_rd = 0, ctl_wr = 0, tick16 = 0;
  logic [7:0] wr_char = 0, ctl_data = 0;
  logic [7:0] rd_char, status;
  logic [4:0] level;
  logic rda_req, cto_req, tx_flush, dma_sel;
  int total = 0, bad = 0;
  bit done = 0;

  uart_rx_queue #(.DEPTH(DEPTH), .CHAR_TICKS(CT)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
    .rd_en(rd_en), .stat_rd(stat_rd), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .tick16(tick16), .rd_char(rd_char), .status(status), .level(level),
    .rda_req(rda_req), .cto_req(cto_req), .tx_flush(tx_flush), .dma_sel(dma_sel)
  );

  always #4 clk = ~clk;

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    wr_en = 1; wr_char = d; {wr_brk, wr_ferr, wr_perr} = f;
    step;
    wr_en = 0; {wr_brk, wr_ferr, wr_perr} = 3'b000;
  endtask

  task automatic pop;
    rd_en = 1; step; rd_en = 0;
  endtask

  task automatic ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_data = v; step; ctl_wr = 0;
  endtask

  task automatic sread;
    stat_rd = 1; step; stat_rd = 0;
  endtask

  function automatic logic [7:0] dval(input int k, input int c);
    return 8'((k * 7 + c * 3) % 256);
  endfunction

  function automatic logic [2:0] fval(input int k);
    return 3'((k * 3) % 8);
  endfunction

  function automatic int thr_of(input int c);
    case (c) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  function automatic int any_err(input int from);
    for (int j = from; j <= DEPTH; j++) if (fval(j) != 0) return 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step; step; rst = 0; step;
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 status", status, 0);
    chk("R1 rda", rda_req, 0);
    chk("R1 cto", cto_req, 0);
    chk("R1 tx_flush", tx_flush, 0);
    chk("R1 dma", dma_sel, 0);

    // R4 / R2 / R3 / R6 sweep over all trigger codes
    ctl(8'h01);
    for (int c = 0; c < 4; c++) begin
      ctl({2'(c), 4'b0000, 2'b11});
      chk("R5 flush level", level, 0);
      for (int k = 1; k <= DEPTH; k++) begin
        push(dval(k, c), fval(k));
        chk("R2 level", level, k);
        chk("R4 rda", rda_req, (k >= thr_of(c)) ? 1 : 0);
      end
      push(8'hEE, 3'b111);
      chk("R3 full level", level, DEPTH);
      chk("R3 overrun set", status[1], 1);
      sread;
      chk("R3 overrun clear", status[1], 0);
      for (int k = 1; k <= DEPTH; k++) begin
        chk("R2 data", rd_char, dval(k, c));
        chk("R6 head flags", status[4:2], fval(k));
        chk("R6 any error", status[7], any_err(k));
        chk("R6 ready", status[0], 1);
        pop;
      end
      chk("R2 empty", level, 0);
      chk("R6 status empty", status, 0);
      pop;
      chk("R3 empty read", level, 0);
    end

    // R10 simultaneous write and read on full queue
    for (int k = 1; k <= DEPTH; k++) push(8'(k), 3'b000);
    wr_en = 1; wr_char = 8'hA5; rd_en = 1; step; wr_en = 0; rd_en = 0;
    chk("R10 level", level, DEPTH);
    chk("R10 no overrun", status[1], 0);
    chk("R10 head", rd_char, 2);

    // R5 flush, tx pulse, dma
    push(8'h00, 3'b100);
    ctl(8'h05);
    chk("R5 tx pulse", tx_flush, 1);
    chk("R5 tx keeps rx", level, DEPTH);
    step;
    chk("R5 tx single", tx_flush, 0);
    ctl(8'h03);
    chk("R5 rx flush", level, 0);
    chk("R5 err clear", status[7], 0);
    chk("R5 tx quiet", tx_flush, 0);
    ctl(8'h09);
    chk("R5 dma", dma_sel, 1);
    ctl(8'h01);
    chk("R5 dma off", dma_sel, 0);

    // R7 timeout
    tick16 = 1;
    push(8'h31, 3'b000);
    for (int i = 0; i < LIM - 1; i++) step;
    chk("R7 cto early", cto_req, 0);
    step;
    chk("R7 cto fire", cto_req, 1);
    push(8'h32, 3'b000);
    chk("R7 cto write clr", cto_req, 0);
    for (int i = 0; i < LIM - 2; i++) step;
    push(8'h33, 3'b000);
    for (int i = 0; i < LIM - 1; i++) step;
    chk("R7 cto restart", cto_req, 0);
    step;
    chk("R7 cto refire", cto_req, 1);
    pop;
    chk("R7 cto read clr", cto_req, 0);
    tick16 = 0;
    for (int i = 0; i < 3 * LIM; i++) step;
    chk("R7 no tick", cto_req, 0);
    ctl(8'h03);

    // R8 single holding register
    ctl(8'h00);
    chk("R9 tx on mode", tx_flush, 1);
    push(8'h41, 3'b010);
    chk("R8 level1", level, 1);
    chk("R8 rda", rda_req, 1);
    push(8'h42, 3'b000);
    chk("R8 level hold", level, 1);
    chk("R8 overrun", status[1], 1);
    chk("R8 head", rd_char, 8'h41);
    tick16 = 1;
    for (int i = 0; i < 2 * LIM; i++) step;
    chk("R8 no cto", cto_req, 0);
    tick16 = 0;
    sread;
    pop;
    chk("R8 empty", level, 0);

    // R9 mode change flushes
    push(8'h51, 3'b000);
    ctl(8'h01);
    chk("R9 flush on enable", level, 0);
    push(8'h52, 3'b000); push(8'h53, 3'b000); push(8'h54, 3'b000);
    ctl(8'h41);
    chk("R9 same mode keeps", level, 3);
    ctl(8'h00);
    chk("R9 flush on disable", level, 0);
    push(8'h55, 3'b000);
    ctl(8'h00);
    chk("R9 same mode keeps off", level, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule